// File: doc/BRIEF.md
# Multi-Chip-Select Asynchronous Memory Bus Controller

The controller turns single accesses from an internal request port into strobe sequences on an external parallel asynchronous memory bus. Up to six devices share the bus, each with its own active-low select line. Every select has an enable bit and two 32-bit timing words, `slow` and `fast`, supplied as inputs. These words set the wait, hold, recovery, lead and first-access latency for any access to that device.

A request carries an address, write data, a write flag and a chip-select index. It is taken in the cycle `req_valid_i` and `req_ready_o` are both high. A request to a disabled or out-of-range select is taken and dropped, with no bus activity. An enabled request runs through a sequencer with these states: IDLE, RECOV (turnaround gap), SETUP (select asserted with a one-cycle ADV pulse), LAT (first-access latency), LEAD (read gap before OE), STRB (OE or WE active) and HOLD (write data kept on the bus after WE). Read data is captured on the last OE cycle and returned with a one-cycle response pulse.

Transitions: IDLE→RECOV on acceptance when turnaround is needed, IDLE→SETUP otherwise. RECOV→SETUP when the count expires. SETUP→LAT when latency applies, else SETUP→LEAD (read with a nonzero lead) or SETUP→STRB. LAT→LEAD or LAT→STRB by the same rule. LEAD→STRB. STRB→HOLD for a write with a nonzero hold, else STRB→IDLE. HOLD→IDLE.

Top module: `xbus_ctrl`

## Requirements
- R1: Select lines are active-low and at most one is low at a time; line n goes low only for an access to index n. A request whose index is 6 or higher, or whose bit in `cs_en_i` is 0, is accepted while `req_ready_o` stays high, drives no strobe and gives no response.
- R2: A read holds `mem_oe_no` low for `slow[3:0]`+1 consecutive cycles.
- R3: A write holds `mem_we_no` low for `slow[7:4]`+1 consecutive cycles and drives the request's write data on `mem_wdata_o` while `mem_wdata_oe_o` is high.
- R4: When the previous enabled access was a read and the new one targets another select or is a write, the bus stays idle for `slow[31:28]`+1 cycles of the previous select plus one ready cycle between the two accesses. Otherwise a back-to-back access follows after a single idle cycle.
- R5: After WE is released, the select line and `mem_wdata_oe_o` stay active for `slow[27:24]` more cycles. Reads have no hold.
- R6: An access is a first access when it is the first since reset, when its select differs from the previous enabled access, or when `addr[AW-1:4]` differs from that access. A first access inserts `slow[15:8]` cycles (read) or `slow[23:16]` cycles (write) after the ADV cycle. A write's WE goes low 1+latency cycles after the ADV cycle.
- R7: For a read, OE first goes low 1+latency+max(`fast[27:24]`, `fast[17:16]`) cycles after the ADV cycle.
- R8: The address appears on `mem_addr_o` in the ADV cycle, and also in the next cycle when `fast[5]` is set. At all other times `mem_addr_o` is zero.
- R9: `mem_adv_no` is low for exactly one cycle per access: the first cycle in which the select line is low.
- R10: Read data present on the last OE-low cycle is returned on `rsp_rdata_o` with `rsp_valid_o` high for one cycle, in the cycle right after OE rises.
- R11: After reset all strobes are high, the address and data outputs are zero and `req_ready_o` is high. `req_ready_o` stays low from acceptance of an enabled request until its last hold cycle, and through any recovery of the next one.
- R12: OE and WE are never low together, and the write-data output enable is never high while OE is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready (sequencer idle) |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_cs_i | input | CSW (3) | Chip-select index |
| req_addr_i | input | AW (24) | Access address |
| req_wdata_i | input | DW (16) | Write data |
| rsp_valid_o | output | 1 | One-cycle read response pulse |
| rsp_rdata_o | output | DW (16) | Captured read data |
| cs_en_i | input | NCS (6) | Per-select enable |
| slow_cfg_i | input | NCS*32 | Slow timing words, select n at bits [32n+31:32n] |
| fast_cfg_i | input | NCS*32 | Fast timing words, same packing |
| mem_cs_no | output | NCS (6) | Active-low chip selects |
| mem_oe_no | output | 1 | Active-low output enable |
| mem_we_no | output | 1 | Active-low write enable |
| mem_adv_no | output | 1 | Active-low address-valid pulse |
| mem_addr_o | output | AW (24) | Memory address |
| mem_wdata_o | output | DW (16) | Write data to memory |
| mem_wdata_oe_o | output | 1 | Write-data output enable |
| mem_rdata_i | input | DW (16) | Read data from memory |

## Verification
The assertions assume that the timing words and enable bits do not change while an access is in flight, and that the request fields stay steady while `req_valid_i` is high. The bench sets every configuration word before reset is released and never touches them again. It holds each request steady from the cycle it raises valid until the cycle after acceptance. The memory model drives read data only while OE is low, so a missing or early strobe shows up as a wrong response value.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    localparam int CFG_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECOV,
        ST_SETUP,
        ST_LAT,
        ST_LEAD,
        ST_STRB,
        ST_HOLD
    } xbus_state_e;

    typedef struct packed {
        logic [3:0] recov;
        logic [3:0] wr_hold;
        logic [7:0] wr_delta;
        logic [7:0] rd_delta;
        logic [3:0] wr_wait;
        logic [3:0] rd_wait;
        logic [3:0] rd_lead;
        logic [1:0] adv_oe;
        logic       addr_hold;
    } xbus_tim_t;

    function automatic xbus_tim_t xbus_decode(input logic [CFG_W-1:0] s,
                                              input logic [CFG_W-1:0] f);
        xbus_tim_t t;
        t.recov     = s[31:28];
        t.wr_hold   = s[27:24];
        t.wr_delta  = s[23:16];
        t.rd_delta  = s[15:8];
        t.wr_wait   = s[7:4];
        t.rd_wait   = s[3:0];
        t.rd_lead   = f[27:24];
        t.adv_oe    = f[17:16];
        t.addr_hold = f[5];
        return t;
    endfunction

endpackage

// File: rtl/xbus_cfg_sel.sv
module xbus_cfg_sel
    import xbus_pkg::*;
#(
    parameter int NCS = 6,
    parameter int CSW = 3
) (
    input  logic [CSW-1:0]       sel_i,
    input  logic [NCS*CFG_W-1:0] slow_i,
    input  logic [NCS*CFG_W-1:0] fast_i,
    output xbus_tim_t            tim_o
);

    xbus_tim_t tim_a [NCS];

    for (genvar g = 0; g < NCS; g++) begin : g_dec
        logic [CFG_W-1:0] fw;
        logic             unused_fast_bits;
        assign fw = fast_i[g*CFG_W +: CFG_W];
        assign tim_a[g] = xbus_decode(slow_i[g*CFG_W +: CFG_W], fw);
        assign unused_fast_bits = ^{fw[31:28], fw[23:18], fw[15:6], fw[4:0]};
    end

    always_comb begin
        tim_o = tim_a[0];
        for (int i = 1; i < NCS; i++) begin
            if (sel_i == CSW'(i)) tim_o = tim_a[i];
        end
    end

endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
    import xbus_pkg::*;
#(
    parameter int NCS    = 6,
    parameter int CSW    = 3,
    parameter int AW     = 24,
    parameter int DW     = 16,
    parameter int PAGE_W = 4,
    parameter int CNT_W  = 8
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          req_valid_i,
    input  logic          req_we_i,
    input  logic [CSW-1:0] req_cs_i,
    input  logic [AW-1:0] req_addr_i,
    input  logic [DW-1:0] req_wdata_i,
    input  logic [NCS-1:0] cs_en_i,
    input  xbus_tim_t     tim_i,
    input  logic [DW-1:0] mem_rdata_i,
    output xbus_state_e   state_o,
    output logic [CSW-1:0] cs_o,
    output logic          we_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] wdata_o,
    output logic          post_adv_o,
    output logic          rsp_valid_o,
    output logic [DW-1:0] rsp_rdata_o
);

    localparam int PGW = AW - PAGE_W;

    xbus_state_e    state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic           first_q, last_rd_q, seen_q;
    logic [PGW-1:0] last_page_q;
    logic           req_en, go, need_rec, first_new;
    logic [7:0]     delta;
    logic [3:0]     lead;

    always_comb begin
        req_en = 1'b0;
        for (int i = 0; i < NCS; i++) begin
            if (req_cs_i == CSW'(i) && cs_en_i[i]) req_en = 1'b1;
        end
    end

    assign go        = req_valid_i && (state_q == ST_IDLE) && req_en;
    assign need_rec  = last_rd_q && ((req_cs_i != cs_o) || req_we_i);
    assign first_new = !seen_q || (req_cs_i != cs_o) ||
                       (req_addr_i[AW-1:PAGE_W] != last_page_q);
    assign delta     = first_q ? (we_o ? tim_i.wr_delta : tim_i.rd_delta) : 8'd0;
    assign lead      = (tim_i.rd_lead > {2'b00, tim_i.adv_oe}) ? tim_i.rd_lead
                                                               : {2'b00, tim_i.adv_oe};

    // next state and count
    always_comb begin
        state_d = state_q;
        cnt_d   = (cnt_q != '0) ? cnt_q - 1'b1 : cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go) begin
                    if (need_rec) begin
                        state_d = ST_RECOV;
                        cnt_d   = CNT_W'(tim_i.recov);
                    end else begin
                        state_d = ST_SETUP;
                    end
                end
            end
            ST_RECOV: if (cnt_q == '0) state_d = ST_SETUP;
            ST_SETUP, ST_LAT: begin
                if (state_q == ST_SETUP && delta != 8'd0) begin
                    state_d = ST_LAT;
                    cnt_d   = CNT_W'(delta - 8'd1);
                end else if (state_q == ST_SETUP || cnt_q == '0) begin
                    if (!we_o && lead != 4'd0) begin
                        state_d = ST_LEAD;
                        cnt_d   = CNT_W'(lead - 4'd1);
                    end else begin
                        state_d = ST_STRB;
                        cnt_d   = CNT_W'(we_o ? tim_i.wr_wait : tim_i.rd_wait);
                    end
                end
            end
            ST_LEAD: begin
                if (cnt_q == '0) begin
                    state_d = ST_STRB;
                    cnt_d   = CNT_W'(tim_i.rd_wait);
                end
            end
            ST_STRB: begin
                if (cnt_q == '0) begin
                    if (we_o && tim_i.wr_hold != 4'd0) begin
                        state_d = ST_HOLD;
                        cnt_d   = CNT_W'(tim_i.wr_hold - 4'd1);
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_HOLD: if (cnt_q == '0) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // request capture, history and read capture
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cs_o        <= '0;
            we_o        <= 1'b0;
            addr_o      <= '0;
            wdata_o     <= '0;
            first_q     <= 1'b0;
            last_rd_q   <= 1'b0;
            seen_q      <= 1'b0;
            last_page_q <= '0;
            post_adv_o  <= 1'b0;
            rsp_valid_o <= 1'b0;
            rsp_rdata_o <= '0;
        end else begin
            if (go) begin
                cs_o        <= req_cs_i;
                we_o        <= req_we_i;
                addr_o      <= req_addr_i;
                wdata_o     <= req_wdata_i;
                first_q     <= first_new;
                last_rd_q   <= !req_we_i;
                seen_q      <= 1'b1;
                last_page_q <= req_addr_i[AW-1:PAGE_W];
            end
            post_adv_o  <= (state_q == ST_SETUP);
            rsp_valid_o <= (state_q == ST_STRB) && !we_o && (cnt_q == '0);
            if ((state_q == ST_STRB) && !we_o && (cnt_q == '0))
                rsp_rdata_o <= mem_rdata_i;
        end
    end

    assign state_o = state_q;

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int NCS    = 6,
    parameter int AW     = 24,
    parameter int DW     = 16,
    parameter int PAGE_W = 4,
    localparam int CSW   = (NCS > 1) ? $clog2(NCS) : 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               req_valid_i,
    output logic               req_ready_o,
    input  logic               req_we_i,
    input  logic [CSW-1:0]     req_cs_i,
    input  logic [AW-1:0]      req_addr_i,
    input  logic [DW-1:0]      req_wdata_i,
    output logic               rsp_valid_o,
    output logic [DW-1:0]      rsp_rdata_o,
    input  logic [NCS-1:0]     cs_en_i,
    input  logic [NCS*32-1:0]  slow_cfg_i,
    input  logic [NCS*32-1:0]  fast_cfg_i,
    output logic [NCS-1:0]     mem_cs_no,
    output logic               mem_oe_no,
    output logic               mem_we_no,
    output logic               mem_adv_no,
    output logic [AW-1:0]      mem_addr_o,
    output logic [DW-1:0]      mem_wdata_o,
    output logic               mem_wdata_oe_o,
    input  logic [DW-1:0]      mem_rdata_i
);

    xbus_state_e    state;
    logic [CSW-1:0] cs_q;
    logic           we_q, post_adv;
    logic [AW-1:0]  addr_q;
    logic [DW-1:0]  wdata_q;
    xbus_tim_t      tim;
    logic           busy;

    xbus_cfg_sel #(.NCS(NCS), .CSW(CSW)) u_cfg (
        .sel_i  (cs_q),
        .slow_i (slow_cfg_i),
        .fast_i (fast_cfg_i),
        .tim_o  (tim)
    );

    xbus_seq #(.NCS(NCS), .CSW(CSW), .AW(AW), .DW(DW), .PAGE_W(PAGE_W)) u_seq (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .req_valid_i (req_valid_i),
        .req_we_i    (req_we_i),
        .req_cs_i    (req_cs_i),
        .req_addr_i  (req_addr_i),
        .req_wdata_i (req_wdata_i),
        .cs_en_i     (cs_en_i),
        .tim_i       (tim),
        .mem_rdata_i (mem_rdata_i),
        .state_o     (state),
        .cs_o        (cs_q),
        .we_o        (we_q),
        .addr_o      (addr_q),
        .wdata_o     (wdata_q),
        .post_adv_o  (post_adv),
        .rsp_valid_o (rsp_valid_o),
        .rsp_rdata_o (rsp_rdata_o)
    );

    // output decode
    always_comb begin
        busy = (state != ST_IDLE) && (state != ST_RECOV);
        for (int i = 0; i < NCS; i++) begin
            mem_cs_no[i] = !(busy && (cs_q == CSW'(i)));
        end
        req_ready_o    = (state == ST_IDLE);
        mem_adv_no     = (state != ST_SETUP);
        mem_oe_no      = !((state == ST_STRB) && !we_q);
        mem_we_no      = !((state == ST_STRB) && we_q);
        mem_wdata_oe_o = we_q && ((state == ST_STRB) || (state == ST_HOLD));
        mem_wdata_o    = mem_wdata_oe_o ? wdata_q : '0;
        mem_addr_o     = ((state == ST_SETUP) || (post_adv && tim.addr_hold)) ? addr_q : '0;
    end

endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk #(
    parameter int NCS = 6,
    parameter int CSW = 3
) (
    input logic           clk_i,
    input logic           rst_ni,
    input logic           req_valid_i,
    input logic           req_ready_o,
    input logic [CSW-1:0] req_cs_i,
    input logic [NCS-1:0] cs_en_i,
    input logic [NCS-1:0] mem_cs_no,
    input logic           mem_oe_no,
    input logic           mem_we_no,
    input logic           mem_adv_no,
    input logic           mem_wdata_oe_o,
    input logic           rsp_valid_o
);

    logic req_en;
    always_comb begin
        req_en = 1'b0;
        for (int i = 0; i < NCS; i++) begin
            if (req_cs_i == CSW'(i) && cs_en_i[i]) req_en = 1'b1;
        end
    end

    assert_cs_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(~mem_cs_no) <= 1);

    assert_disabled_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_ready_o && !req_en) |=> (mem_cs_no == '1));

    assert_adv_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mem_adv_no |=> mem_adv_no);

    assert_adv_in_cs_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mem_adv_no |-> (mem_cs_no != '1));

    assert_rsp_after_oe_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_valid_o |-> (mem_oe_no && $past(!mem_oe_no)));

    assert_busy_not_ready_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_cs_no != '1) |-> !req_ready_o);

    assert_strobe_excl_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(!mem_oe_no && !mem_we_no));

    assert_no_contention_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !mem_oe_no |-> !mem_wdata_oe_o);

endmodule

bind xbus_ctrl xbus_ctrl_chk #(.NCS(NCS), .CSW(CSW)) u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_valid_i    (req_valid_i),
    .req_ready_o    (req_ready_o),
    .req_cs_i       (req_cs_i),
    .cs_en_i        (cs_en_i),
    .mem_cs_no      (mem_cs_no),
    .mem_oe_no      (mem_oe_no),
    .mem_we_no      (mem_we_no),
    .mem_adv_no     (mem_adv_no),
    .mem_wdata_oe_o (mem_wdata_oe_o),
    .rsp_valid_o    (rsp_valid_o)
);

// File: tb/xbus_ctrl_tb_top.sv
module xbus_ctrl_tb_top;

    localparam int NCS = 6;
    localparam int CSW = 3;
    localparam int AW  = 24;
    localparam int DW  = 16;
    localparam int PW  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2ns clk = ~clk;

    logic           req_valid = 1'b0, req_ready, req_we = 1'b0;
    logic [CSW-1:0] req_cs = '0;
    logic [AW-1:0]  req_addr = '0;
    logic [DW-1:0]  req_wdata = '0;
    logic           rsp_valid;
    logic [DW-1:0]  rsp_rdata;
    logic [NCS-1:0] cs_en;
    logic [NCS*32-1:0] slow_flat, fast_flat;
    logic [NCS-1:0] mem_cs_n;
    logic           mem_oe_n, mem_we_n, mem_adv_n, mem_doe;
    logic [AW-1:0]  mem_addr;
    logic [DW-1:0]  mem_wdata, mem_rdata;

    logic [31:0] slow_c [NCS];
    logic [31:0] fast_c [NCS];

    always_comb begin
        for (int i = 0; i < NCS; i++) begin
            slow_flat[i*32 +: 32] = slow_c[i];
            fast_flat[i*32 +: 32] = fast_c[i];
        end
    end

    xbus_ctrl dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
        .req_cs_i(req_cs), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
        .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
        .cs_en_i(cs_en), .slow_cfg_i(slow_flat), .fast_cfg_i(fast_flat),
        .mem_cs_no(mem_cs_n), .mem_oe_no(mem_oe_n), .mem_we_no(mem_we_n),
        .mem_adv_no(mem_adv_n), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
        .mem_wdata_oe_o(mem_doe), .mem_rdata_i(mem_rdata)
    );

    // memory model: data depends on the address seen with ADV
    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        return a[DW-1:0] ^ 16'h5A3C;
    endfunction

    logic [AW-1:0] adv_addr = '0;
    always @(negedge clk) if (!mem_adv_n) adv_addr <= mem_addr;
    assign mem_rdata = !mem_oe_n ? pat(adv_addr) : '0;

    int n_cmp = 0, n_bad = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    typedef struct {
        int            cs;
        bit            we;
        int            lead;
        int            strb;
        int            hold;
        int            adrw;
        int            doe;
        int            gap;
        logic [AW-1:0] addr;
        logic [DW-1:0] wd;
    } exp_t;

    exp_t          tq[$];
    logic [DW-1:0] rq[$];

    // history for expected timing
    bit            h_valid = 0, h_rd = 0;
    int            h_cs = 0;
    logic [AW-PW-1:0] h_page = '0;

    // driver
    task automatic access(input bit we, input int cs, input logic [AW-1:0] a,
                          input logic [DW-1:0] d);
        exp_t e;
        bit busy, en, first, rec;
        int dl, g;
        @(negedge clk);
        busy = !req_ready;
        en = (cs < NCS) && cs_en[cs];
        if (en) begin
            first = !h_valid || (cs != h_cs) || (a[AW-1:PW] != h_page);
            dl = first ? int'(we ? slow_c[cs][23:16] : slow_c[cs][15:8]) : 0;
            g  = (fast_c[cs][27:24] > {2'b00, fast_c[cs][17:16]}) ?
                 int'(fast_c[cs][27:24]) : int'(fast_c[cs][17:16]);
            rec = h_valid && h_rd && ((cs != h_cs) || we);
            e.cs   = cs;
            e.we   = we;
            e.lead = we ? 1 + dl : 1 + dl + g;
            e.strb = int'(we ? slow_c[cs][7:4] : slow_c[cs][3:0]) + 1;
            e.hold = we ? int'(slow_c[cs][27:24]) : 0;
            e.adrw = 1 + int'(fast_c[cs][5]);
            e.doe  = we ? e.strb + e.hold : 0;
            e.gap  = busy ? (rec ? int'(slow_c[h_cs][31:28]) + 2 : 1) : -1;
            e.addr = a;
            e.wd   = d;
            tq.push_back(e);
            if (!we) rq.push_back(pat(a));
            h_valid = 1; h_rd = !we; h_cs = cs; h_page = a[AW-1:PW];
        end
        req_we = we; req_cs = CSW'(cs); req_addr = a; req_wdata = d;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (en) chk(!req_ready, "R11", "ready after accept", req_ready, 0);
        else    chk(req_ready, "R1", "ready after dropped request", req_ready, 1);
    endtask

    task automatic wait_idle();
        int quiet = 0;
        while (quiet < 4) begin
            @(negedge clk);
            if (req_ready && mem_cs_n == '1 && !req_valid) quiet++; else quiet = 0;
        end
    endtask

    // monitor / scoreboard
    bit            in_acc = 0, prev_oe_low = 0, cs_bad = 0, wd_bad = 0, adv0 = 0;
    int            m_idx, m_lead, m_oe, m_we, m_hold, m_adr, m_adv, m_doe;
    int            gap_cnt = 0, m_gap;
    int            acc_cnt = 0, rsp_cnt = 0;
    logic [NCS-1:0] m_cs;
    logic [AW-1:0] m_addr;
    logic [DW-1:0] m_wd;

    always @(negedge clk) begin
        if (rst_n) begin
            if (rsp_valid) begin
                rsp_cnt++;
                chk(prev_oe_low, "R10", "response right after OE rise", prev_oe_low, 1);
                if (rq.size() == 0) chk(0, "R10", "unexpected response", rsp_rdata, -1);
                else begin
                    logic [DW-1:0] x;
                    x = rq.pop_front();
                    chk(rsp_rdata == x, "R10", "read data", rsp_rdata, x);
                end
            end
            prev_oe_low = !mem_oe_n;
            if (mem_cs_n != '1) begin
                if (!in_acc) begin
                    in_acc = 1; m_idx = 0; m_lead = -1; m_oe = 0; m_we = 0;
                    m_hold = 0; m_adr = 0; m_adv = 0; m_doe = 0; cs_bad = 0;
                    wd_bad = 0; m_cs = ~mem_cs_n; m_addr = mem_addr;
                    m_gap = gap_cnt; adv0 = !mem_adv_n; m_wd = '0;
                end else begin
                    m_idx++;
                    if (~mem_cs_n != m_cs) cs_bad = 1;
                end
                if (!mem_adv_n) m_adv++;
                if (mem_addr != '0) m_adr++;
                if (!mem_oe_n || !mem_we_n) if (m_lead < 0) m_lead = m_idx;
                if (!mem_oe_n) m_oe++;
                if (!mem_we_n) m_we++;
                if (m_we > 0 && mem_we_n) m_hold++;
                if (mem_doe) begin
                    if (m_doe == 0) m_wd = mem_wdata;
                    else if (mem_wdata != m_wd) wd_bad = 1;
                    m_doe++;
                end
            end else begin
                if (in_acc) begin
                    exp_t e;
                    in_acc = 0;
                    acc_cnt++;
                    gap_cnt = 1;
                    if (tq.size() == 0) chk(0, "R1", "unexpected bus cycle", m_cs, 0);
                    else begin
                        e = tq.pop_front();
                        chk(m_cs == NCS'(1 << e.cs) && !cs_bad, "R1", "select line", m_cs, 1 << e.cs);
                        chk(m_adv == 1 && adv0, "R9", "ADV pulses", m_adv, 1);
                        chk(m_lead == e.lead, e.we ? "R6" : "R7", "strobe lead", m_lead, e.lead);
                        if (e.we) begin
                            chk(m_we == e.strb, "R3", "WE length", m_we, e.strb);
                            chk(m_oe == 0, "R12", "OE during write", m_oe, 0);
                            chk(m_wd == e.wd && !wd_bad, "R3", "write data", m_wd, e.wd);
                        end else begin
                            chk(m_oe == e.strb, "R2", "OE length", m_oe, e.strb);
                            chk(m_we == 0, "R12", "WE during read", m_we, 0);
                        end
                        chk(m_hold == e.hold, "R5", "hold cycles", m_hold, e.hold);
                        chk(m_doe == e.doe, "R5", "data drive cycles", m_doe, e.doe);
                        chk(m_adr == e.adrw, "R8", "address window", m_adr, e.adrw);
                        chk(m_addr == e.addr, "R8", "address value", m_addr, e.addr);
                        if (e.gap >= 0)
                            chk(m_gap == e.gap, "R4", "idle gap", m_gap, e.gap);
                    end
                end else begin
                    gap_cnt++;
                end
            end
        end
    end

    bit done = 0;

    initial begin
        #(400000ns);
        if (!done) begin
            chk(0, "R11", "watchdog expired", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // select 0: mixed timing
        slow_c[0] = {4'd2, 4'd1, 8'd3, 8'd2, 4'd1, 4'd2};
        fast_c[0] = 32'h0 | (32'd1 << 24) | (32'd3 << 16) | (32'd1 << 5);
        // select 1: all minimum
        slow_c[1] = 32'h0;
        fast_c[1] = 32'h0;
        // select 2: maximum four-bit counts
        slow_c[2] = {4'd15, 4'd15, 8'd0, 8'd0, 4'd15, 4'd15};
        fast_c[2] = (32'd15 << 24);
        // select 3: disabled
        slow_c[3] = 32'h0000_0101;
        fast_c[3] = 32'h0;
        // select 4: read latency, lead from ADV-to-OE field
        slow_c[4] = {4'd1, 4'd0, 8'd0, 8'd10, 4'd0, 4'd1};
        fast_c[4] = (32'd1 << 24) | (32'd2 << 16);
        // select 5: write latency and address hold
        slow_c[5] = {4'd0, 4'd2, 8'd5, 8'd0, 4'd3, 4'd0};
        fast_c[5] = (32'd3 << 16) | (32'd1 << 5);
        cs_en = 6'b110111;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_cs_n == '1, "R11", "reset selects", mem_cs_n, 63);
        chk(mem_oe_n && mem_we_n && mem_adv_n, "R11", "reset strobes",
            {mem_oe_n, mem_we_n, mem_adv_n}, 7);
        chk(req_ready, "R11", "reset ready", req_ready, 1);
        chk(!rsp_valid && !mem_doe && mem_addr == '0, "R11", "reset outputs",
            mem_addr, 0);

        // select 0 sequence
        access(1, 0, 24'h000123, 16'hBEEF);
        access(0, 0, 24'h000125, 16'h0);
        access(0, 0, 24'h000126, 16'h0);
        access(1, 0, 24'h000127, 16'h1234);
        access(0, 0, 24'h000230, 16'h0);
        // select 1 after a read on select 0
        access(0, 1, 24'h100011, 16'h0);
        access(1, 1, 24'h100012, 16'hA5A5);
        access(0, 1, 24'h100013, 16'h0);
        // select 2 maxima
        access(0, 2, 24'h200001, 16'h0);
        access(0, 1, 24'h100014, 16'h0);
        access(1, 2, 24'h200002, 16'hC0DE);
        wait_idle();

        // dropped requests: disabled select 3 and out-of-range index 7
        begin
            int a0, r0;
            a0 = acc_cnt; r0 = rsp_cnt;
            access(0, 3, 24'h300001, 16'h0);
            access(1, 7, 24'h700001, 16'h7777);
            repeat (10) @(negedge clk);
            chk(acc_cnt == a0, "R1", "bus cycles for dropped requests", acc_cnt, a0);
            chk(rsp_cnt == r0, "R1", "responses for dropped requests", rsp_cnt, r0);
        end

        // select 4 page latency
        access(0, 4, 24'h400010, 16'h0);
        access(0, 4, 24'h40001F, 16'h0);
        access(0, 4, 24'h400020, 16'h0);
        // select 5 writes
        access(1, 5, 24'h500041, 16'h1111);
        access(1, 5, 24'h500042, 16'h2222);
        access(1, 5, 24'h500051, 16'h3333);
        // back to select 0 after a write: no recovery, first access
        access(0, 0, 24'h000231, 16'h0);
        access(0, 4, 24'h400021, 16'h0);
        wait_idle();

        chk(tq.size() == 0, "R1", "pending bus cycles", tq.size(), 0);
        chk(rq.size() == 0, "R10", "pending responses", rq.size(), 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule